// File: doc/BRIEF.md
# Paged Nonvolatile Write Collector

This block sits behind the serial front end of a small byte-addressed nonvolatile memory. It gathers the bytes of one write session into a page-sized staging buffer. When the session closes, it commits them to the array in a single timed programming cycle. The front end gives it three one-cycle strobes: a start address, each received data byte, and the end of the session, taken from the chip-select rising edge. It also gives it one permit level, the already-combined result of the write-enable latch and the protection checks.

Within a session the page part of the address stays fixed. The offset inside the page advances after every byte and wraps from the last byte of the page back to byte 0, so a long session overwrites earlier bytes. A valid mask records which buffer bytes were loaded, and only those bytes reach the array. While the block is busy, the programming walk and then a timed wait run. After that it drops `busy` and pulses a request to clear the write-enable latch.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy`, `wr_en` and `wel_clear` are 0.
- R2: An `addr_load` strobe starts a session: page = `addr_in[10:5]`, in-page offset = `addr_in[4:0]`. Bits `addr_in[15:11]` have no effect.
- R3: Each accepted `byte_load` stores `byte_in` at the current offset and then increments only the offset. The page stays unchanged.
- R4: After offset 31 the offset wraps to 0 of the same page. A later byte at an offset overwrites the earlier one, and only the last value is programmed.
- R5: A programming cycle starts only when all of these hold: `session_end` arrives, an address was loaded in the session, at least one byte was loaded, `write_permit` is 1 and the block is not busy. Otherwise nothing is written and `busy` stays 0.
- R6: During programming, each loaded offset is written exactly once, in increasing offset order, with `wr_addr` = {page, offset} and `wr_data` = the stored byte. Unloaded offsets are never written.
- R7: `busy` rises in the first cycle after the committing `session_end` and stays high for exactly PAGE_BYTES + PROG_CYCLES + 1 cycles.
- R8: `wel_clear` is a single-cycle pulse in the cycle in which `busy` falls. It does not occur for a session that does not commit.
- R9: While `busy` is 1, `addr_load`, `byte_load` and `session_end` are ignored.
- R10: A new `addr_load` clears the valid mask, so bytes loaded before it are not programmed. A `byte_load` with no address loaded in the current session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | Start-address strobe, begins a session |
| addr_in | input | 16 | Received address; low 11 bits significant |
| byte_load | input | 1 | Data-byte strobe |
| byte_in | input | 8 | Received data byte |
| session_end | input | 1 | One-cycle pulse at chip-select rising |
| write_permit | input | 1 | Combined write-enable and protection result |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | 11 | Array write address |
| wr_data | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clear | output | 1 | Pulse requesting the write-enable latch be cleared |

## Verification
Loads take effect at the edge that samples the strobe. `busy` goes high one cycle after the committing `session_end` edge. The write for offset k appears k+1 cycles after that edge, and `busy` and `wel_clear` change together PAGE_BYTES+PROG_CYCLES+1 cycles after it. The bench drives inputs on falling edges. From the falling edge right after `session_end`, it samples every output on every falling edge, counting `busy` cycles and `wel_clear` pulses and comparing each write strobe in order against a model page. The observation window is longer than the busy period, so late or extra writes are also caught.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_mask,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q,
  output logic              mask_bit,
  output logic              any_loaded
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  mask;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
    if (rd_en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_mask) mask <= '0;
    else if (we) mask[wr_idx] <= 1'b1;
  end

  assign mask_bit   = mask[rd_idx];
  assign any_loaded = |mask;

  // a fresh session leaves no loaded bytes behind
  assert_mask_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    clr_mask |=> (mask == '0));
endmodule

// File: rtl/load_pointer.sv
module load_pointer #(
  parameter int PAGE_W = 6,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_accept,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic              byte_accept,
  input  logic              session_close,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  ptr,
  output logic              armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page  <= '0;
      ptr   <= '0;
      armed <= 1'b0;
    end else begin
      if (addr_accept) begin
        page  <= page_in;
        ptr   <= off_in;
        armed <= 1'b1;
      end else if (byte_accept) begin
        ptr <= ptr + 1'b1;
      end
      if (session_close) armed <= 1'b0;
    end
  end

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_accept && !addr_accept) |=> $stable(page));
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_accept && !addr_accept && ptr == {OFF_W{1'b1}}) |=> (ptr == '0));
endmodule

// File: rtl/commit_sequencer.sv
module commit_sequencer
  import eepw_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int OFF_W       = 5,
  parameter int PROG_CYCLES = 5000,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PAGE_W-1:0]       page,
  input  logic                    mask_bit,
  output logic                    rd_en,
  output logic [OFF_W-1:0]        rd_idx,
  output logic                    busy,
  output logic                    wr_en,
  output logic [PAGE_W+OFF_W-1:0] wr_addr,
  output logic                    wel_clear
);
  localparam logic [OFF_W-1:0] LAST_IDX = {OFF_W{1'b1}};

  seq_state_t       state;
  logic [OFF_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      idx       <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wel_clear <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      wel_clear <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_DRAIN;
            idx   <= '0;
            busy  <= 1'b1;
          end
        end
        SEQ_DRAIN: begin
          wr_en   <= mask_bit;
          wr_addr <= {page, idx};
          idx     <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            state <= SEQ_WAIT;
            cnt   <= CNT_W'(PROG_CYCLES);
          end
        end
        SEQ_WAIT: begin
          if (cnt == '0) begin
            state     <= SEQ_IDLE;
            busy      <= 1'b0;
            wel_clear <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_en  = (state == SEQ_DRAIN);
  assign rd_idx = idx;

  assert_write_inside_busy_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
  assert_busy_needs_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_wel_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wel_clear);
  assert_wel_single_R8: assert property (@(posedge clk) disable iff (rst)
    wel_clear |=> !wel_clear);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_IN_W    = 16,
  parameter int ARRAY_ADDR_W = 11,
  parameter int PAGE_BYTES   = 32,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 5000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ARRAY_ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    addr_load,
  input  logic [ADDR_IN_W-1:0]    addr_in,
  input  logic                    byte_load,
  input  logic [DATA_W-1:0]       byte_in,
  input  logic                    session_end,
  input  logic                    write_permit,
  output logic                    wr_en,
  output logic [ARRAY_ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    busy,
  output logic                    wel_clear
);
  logic              armed, any_loaded, mask_bit, rd_en;
  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  ptr, rd_idx;
  logic              addr_ok, byte_ok, end_ok, start;

  assign addr_ok = addr_load && !busy;
  assign byte_ok = byte_load && armed && !busy && !addr_load;
  assign end_ok  = session_end && !busy;
  assign start   = end_ok && armed && any_loaded && write_permit;

  load_pointer #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst),
    .addr_accept(addr_ok),
    .page_in(addr_in[ARRAY_ADDR_W-1:OFF_W]),
    .off_in(addr_in[OFF_W-1:0]),
    .byte_accept(byte_ok),
    .session_close(end_ok),
    .page(page), .ptr(ptr), .armed(armed)
  );

  page_buffer #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst),
    .clr_mask(addr_ok),
    .we(byte_ok), .wr_idx(ptr), .wr_data(byte_in),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_q(wr_data), .mask_bit(mask_bit), .any_loaded(any_loaded)
  );

  commit_sequencer #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst),
    .start(start), .page(page), .mask_bit(mask_bit),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wel_clear(wel_clear)
  );

  assert_idle_inputs_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && byte_load) |=> $stable(ptr));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !wr_en && !wel_clear));
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int PB = 32;
  localparam int PC = 20;
  localparam int BUSY_LEN = PB + PC + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_load = 1'b0, byte_load = 1'b0, session_end = 1'b0, write_permit = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  byte_in = '0;
  logic        wr_en, busy, wel_clear;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  eeprom_page_writer #(.PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst(rst), .addr_load(addr_load), .addr_in(addr_in),
    .byte_load(byte_load), .byte_in(byte_in), .session_end(session_end),
    .write_permit(write_permit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .wel_clear(wel_clear)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // vector: addr[30:15], byte count[14:9], permit[8], first data value[7:0]
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {16'h0000, 6'd1,  1'b1, 8'h11},
    {16'h0123, 6'd4,  1'b1, 8'h20},
    {16'h07FC, 6'd8,  1'b1, 8'h40},
    {16'hF845, 6'd3,  1'b1, 8'h60},
    {16'h0210, 6'd40, 1'b1, 8'h80},
    {16'h0300, 6'd5,  1'b0, 8'hA0},
    {16'h0100, 6'd0,  1'b1, 8'hC0},
    {16'h03E0, 6'd32, 1'b1, 8'hE0}
  };

  logic       exp_valid [PB];
  logic [7:0] exp_data  [PB];
  logic [5:0] exp_page;
  bit         exp_commit;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < PB; i++) begin
      exp_valid[i] = 1'b0;
      exp_data[i]  = '0;
    end
  endtask

  task automatic model_load(input logic [15:0] a, input int n, input logic [7:0] seed);
    exp_page = a[10:5];
    for (int i = 0; i < n; i++) begin
      exp_valid[(a[4:0] + i) % PB] = 1'b1;
      exp_data[(a[4:0] + i) % PB]  = 8'(seed + i);
    end
  endtask

  task automatic send_addr(input logic [15:0] a);
    @(negedge clk); addr_load = 1'b1; addr_in = a;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_load = 1'b1; byte_in = 8'(seed + i);
    end
    @(negedge clk); byte_load = 1'b0;
  endtask

  // pulse lasts one cycle and returns at the negedge right after the sampling edge
  task automatic send_end(input logic permit);
    @(negedge clk); session_end = 1'b1; write_permit = permit;
    @(negedge clk); session_end = 1'b0;
  endtask

  // samples from the negedge following the session_end edge
  task automatic observe(input string tag);
    int bcyc = 0, welc = 0, wcnt = 0, nxt = 0, expw = 0, wel_ok = 1;
    for (int i = 0; i < PB; i++) if (exp_valid[i]) expw++;
    if (!exp_commit) expw = 0;
    chk(busy == exp_commit, "R7", {tag, " busy one cycle after end"}, busy, exp_commit);
    for (int c = 0; c < BUSY_LEN + 8; c++) begin
      if (busy) bcyc++;
      if (wel_clear) begin
        welc++;
        if (c != BUSY_LEN) wel_ok = 0;
      end
      if (wr_en) begin
        while (nxt < PB && !exp_valid[nxt]) nxt++;
        chk(exp_commit && nxt < PB && wr_addr == {exp_page, 5'(nxt)},
            "R6", {tag, " write address"}, wr_addr, {exp_page, 5'(nxt)});
        if (nxt < PB)
          chk(wr_data == exp_data[nxt], "R4", {tag, " write data"}, wr_data, exp_data[nxt]);
        nxt++;
        wcnt++;
      end
      @(negedge clk);
    end
    chk(wcnt == expw, "R6", {tag, " write count"}, wcnt, expw);
    chk(bcyc == (exp_commit ? BUSY_LEN : 0), "R7", {tag, " busy length"},
        bcyc, exp_commit ? BUSY_LEN : 0);
    chk(welc == (exp_commit ? 1 : 0) && wel_ok, "R8", {tag, " wel_clear pulse"},
        welc, exp_commit ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !wr_en && !wel_clear, "R1", "reset outputs",
        {busy, wr_en, wel_clear}, 0);

    // table: R2 upper bits, R3 increment, R4 wrap/overwrite, R5 gating
    for (int v = 0; v < NV; v++) begin
      logic [15:0] a;
      int n;
      logic pm;
      logic [7:0] sd;
      a = VEC[v][30:15]; n = int'(VEC[v][14:9]); pm = VEC[v][8]; sd = VEC[v][7:0];
      model_clear();
      model_load(a, n, sd);
      exp_commit = pm && (n > 0);
      send_addr(a);
      if (n > 0) send_bytes(n, sd);
      send_end(pm);
      observe($sformatf("R2 R3 R5 vec%0d", v));
    end

    // R10: new address clears earlier loaded bytes
    model_clear();
    send_addr(16'h0043);
    send_bytes(2, 8'h55);
    send_addr(16'h004A);
    send_bytes(1, 8'h77);
    model_load(16'h004A, 1, 8'h77);
    exp_commit = 1'b1;
    send_end(1'b1);
    observe("R10 mask clear");

    // R10: bytes with no address in the session are ignored
    model_clear();
    exp_commit = 1'b0;
    send_bytes(3, 8'h12);
    send_end(1'b1);
    observe("R10 no address");

    // R9: stimulus during busy is ignored
    model_clear();
    send_addr(16'h0281);
    send_bytes(2, 8'h33);
    model_load(16'h0281, 2, 8'h33);
    exp_commit = 1'b1;
    send_end(1'b1);
    fork
      observe("R9 busy");
      begin
        repeat (5) @(negedge clk);
        addr_load = 1'b1; addr_in = 16'h0300;
        @(negedge clk); addr_load = 1'b0; byte_load = 1'b1; byte_in = 8'hEE;
        @(negedge clk); byte_load = 1'b0; session_end = 1'b1; write_permit = 1'b1;
        @(negedge clk); session_end = 1'b0;
      end
    join
    // nothing armed from the busy period: a lone session end must not commit
    model_clear();
    exp_commit = 1'b0;
    send_end(1'b1);
    observe("R9 after busy");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule